// File: doc/BRIEF.md
# Serial Command and Configuration Register Port

This block is a serial slave that gives a host access to a bank of fourteen 8-bit configuration registers. The host frames each transaction with an active-high chip select. It sends a 16-bit word most significant bit first: a 2-bit mode, then a 6-bit address or command code, then a data byte. The block samples serial data on the falling edge of the serial clock. Lowering chip select ends the transaction, and the block acts on it at that moment. A frame that ends too early is dropped.

Besides register write and read, a direct-command mode sends only the 8-bit header. It fires one-shot actions toward the core: it can clear the wake flag, reset the signal-strength measurement, request an oscillator trim, clear the false-wakeup counter, or reload every register default. The core reports wake detections and false wakeups as input pulses. All serial inputs pass through synchronisers and edge detectors into the system clock domain.

A three-state machine runs each transaction:
- ST_IDLE waits for chip select to rise, then moves to ST_SHIFT.
- ST_SHIFT counts bits and captures them. When chip select falls, it moves to ST_EXEC if the frame is complete, or to ST_IDLE otherwise.
- ST_EXEC lasts one cycle and applies the command. It returns to ST_IDLE, or to ST_SHIFT if a new chip-select rise arrives in that cycle.

Top module: `cmdif_top`

## Requirements
- R1: After reset, register i holds i*17 (0x11 per step) for i = 0..12, and register 13 (the false-wakeup counter) holds 0. After reset, wake is low and sdo is low.
- R2: Frames are shifted MSB first and captured on falling serial-clock edges while chip select is high. Bits 15..14 are the mode, bits 13..8 are the address or code, and bits 7..0 are data. A command takes effect only after chip select falls.
- R3: Mode 00 with 16 bits received stores bits 7..0 into the register whose index is bits 13..8, for indices 0..13.
- R4: A write to an address above 13 changes no register. A mode 10 frame changes no register.
- R5: In mode 01, sdo presents the addressed register MSB first, one bit per clock, over the last 8 clocks of the frame. Each bit is valid before the falling edge that samples it. sdo is low outside a read.
- R6: A frame ended by chip select before 16 bits (or before 8 bits in mode 11) has no effect.
- R7: Mode 11 runs the command code in bits 13..8 once 8 bits have arrived. The codes are 0 = clear wake, 1 = RSSI reset, 2 = trim request, 3 = clear register 13, 4 = load defaults. Any data bits that follow are ignored, and other codes do nothing.
- R8: The RSSI-reset and trim-request outputs are single-cycle pulses, exactly one per matching command.
- R9: A wake_set pulse raises wake, and it stays high until a clear-wake command. The clear wins if both happen in the same cycle.
- R10: Each false_wake pulse adds one to register 13, which saturates at 255. A command that updates register 13 in the same cycle takes precedence.
- R11: The load-defaults command restores every register to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data to host |
| wake_set | input | 1 | Wake detection pulse from core |
| false_wake | input | 1 | False-wakeup pulse from core |
| wake | output | 1 | Wake flag level |
| rssi_rst | output | 1 | Signal-strength measurement reset pulse |
| trim_req | output | 1 | Oscillator trim request pulse |
| cfg_flat | output | 112 | All registers, register i at bits [8i+7:8i] |

## Verification
The embedded properties check, on every cycle, that:
- both command pulses are one cycle wide;
- the false-wakeup counter stays saturated unless a command touches it;
- a clear-wake command always leaves wake low;
- a chip-select fall before a complete header never reaches ST_EXEC;
- ST_EXEC is never held.

Only the bench scenarios can show the serial framing itself: bit order, the timing of sdo relative to the sampling edges, and the frame length rules. They also cover which register a write lands in, that writes to out-of-range addresses and truncated frames leave the bank unchanged, and the defaults restored by the load-defaults command.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;

    localparam logic [1:0] MODE_WRITE  = 2'b00;
    localparam logic [1:0] MODE_READ   = 2'b01;
    localparam logic [1:0] MODE_DIRECT = 2'b11;

    localparam logic [5:0] CMD_CLR_WAKE  = 6'd0;
    localparam logic [5:0] CMD_RSSI_RST  = 6'd1;
    localparam logic [5:0] CMD_TRIM      = 6'd2;
    localparam logic [5:0] CMD_CLR_FALSE = 6'd3;
    localparam logic [5:0] CMD_PRESET    = 6'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_EXEC  = 2'd2
    } fsm_e;

    // Default register contents: a ramp in steps of 0x11, counter register zero.
    function automatic logic [7:0] reg_default(input int idx, input int cnt_idx);
        return (idx == cnt_idx) ? 8'h00 : 8'(idx * 17);
    endfunction

endpackage

// File: rtl/cmdif_sync_edge.sv
module cmdif_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], d};
            prev <= sh[STAGES-1];
        end
    end

    always_comb begin
        lvl  = sh[STAGES-1];
        rise = sh[STAGES-1] & ~prev;
        fall = ~sh[STAGES-1] & prev;
    end
endmodule

// File: rtl/cmdif_frame_fsm.sv
module cmdif_frame_fsm
    import cmdif_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_rise,
    input  logic          cs_fall,
    input  logic          sclk_fall,
    input  logic          sdi_bit,
    input  logic [DW-1:0] rd_data,
    output logic          exec_v,
    output logic [1:0]    exec_mode,
    output logic [AW-1:0] exec_code,
    output logic [DW-1:0] exec_data,
    output logic [AW-1:0] rd_addr,
    output logic          sdo
);
    localparam int HB = 2 + AW;
    localparam int FB = HB + DW;
    localparam int CW = $clog2(FB + 1);
    localparam logic [CW-1:0] HB_C  = CW'(HB);
    localparam logic [CW-1:0] HB1_C = CW'(HB - 1);
    localparam logic [CW-1:0] FB_C  = CW'(FB);

    fsm_e          state, state_nx;
    logic [CW-1:0] cnt;
    logic [HB-1:0] hdr;
    logic [DW-1:0] sr;
    logic [DW-1:0] tx;
    logic          ld;
    logic [1:0]    mode;
    logic          frame_ok;
    logic          start;

    assign mode     = hdr[HB-1 -: 2];
    assign frame_ok = ((mode == MODE_DIRECT) && (cnt >= HB_C)) ||
                      ((mode == MODE_WRITE)  && (cnt == FB_C));
    assign start    = (state_nx == ST_SHIFT) && (state != ST_SHIFT);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_rise) state_nx = ST_SHIFT;
            ST_SHIFT: if (cs_fall) state_nx = frame_ok ? ST_EXEC : ST_IDLE;
            ST_EXEC:  state_nx = cs_rise ? ST_SHIFT : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Bit capture: header first, then data byte.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            hdr <= '0;
            sr  <= '0;
            ld  <= 1'b0;
        end else begin
            ld <= 1'b0;
            if (start) begin
                cnt <= '0;
                sr  <= '0;
            end else if (state == ST_SHIFT && sclk_fall && cnt < FB_C) begin
                cnt <= cnt + 1'b1;
                if (cnt < HB_C) hdr <= {hdr[HB-2:0], sdi_bit};
                else            sr  <= {sr[DW-2:0], sdi_bit};
                if (cnt == HB1_C) ld <= 1'b1;
            end
        end
    end

    // Read shifter: loaded after the header, advanced on each later falling edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx <= '0;
        end else if (start) begin
            tx <= '0;
        end else if (state == ST_SHIFT) begin
            if (ld && mode == MODE_READ)       tx <= rd_data;
            else if (sclk_fall && cnt >= HB_C) tx <= {tx[DW-2:0], 1'b0};
        end
    end

    always_comb begin
        exec_v    = (state == ST_EXEC);
        exec_mode = mode;
        exec_code = hdr[AW-1:0];
        exec_data = sr;
        rd_addr   = hdr[AW-1:0];
        sdo       = (state == ST_SHIFT) && (mode == MODE_READ) &&
                    (cnt >= HB_C) && tx[DW-1];
    end

    assert_short_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && cs_fall && cnt < HB_C) |=> (state == ST_IDLE));

    assert_exec_leave_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |=> (state != ST_EXEC));
endmodule

// File: rtl/cmdif_regbank.sv
module cmdif_regbank
    import cmdif_pkg::*;
#(
    parameter int NREGS   = 14,
    parameter int DW      = 8,
    parameter int AW      = 6,
    parameter int CNT_IDX = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                exec_v,
    input  logic [1:0]          exec_mode,
    input  logic [AW-1:0]       exec_code,
    input  logic [DW-1:0]       exec_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data,
    input  logic                wake_set,
    input  logic                false_wake,
    output logic                wake,
    output logic                rssi_rst,
    output logic                trim_req,
    output logic [NREGS*DW-1:0] cfg_flat
);
    localparam int IW = $clog2(NREGS);
    localparam logic [AW-1:0] NREGS_A = AW'(NREGS);

    logic [DW-1:0] regs [NREGS];
    logic is_dir, is_wr, do_preset, do_clr_false, do_clr_wake;

    assign is_dir       = exec_v && (exec_mode == MODE_DIRECT);
    assign is_wr        = exec_v && (exec_mode == MODE_WRITE);
    assign do_preset    = is_dir && (exec_code == CMD_PRESET);
    assign do_clr_false = is_dir && (exec_code == CMD_CLR_FALSE);
    assign do_clr_wake  = is_dir && (exec_code == CMD_CLR_WAKE);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == CNT_IDX) begin : g_cnt
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                regs[g] <= DW'(reg_default(g, CNT_IDX));
                else if (do_preset)                        regs[g] <= DW'(reg_default(g, CNT_IDX));
                else if (is_wr && exec_code == AW'(g))     regs[g] <= exec_data;
                else if (do_clr_false)                     regs[g] <= '0;
                else if (false_wake && regs[g] != '1)      regs[g] <= regs[g] + 1'b1;
            end
        end else begin : g_cfg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                regs[g] <= DW'(reg_default(g, CNT_IDX));
                else if (do_preset)                        regs[g] <= DW'(reg_default(g, CNT_IDX));
                else if (is_wr && exec_code == AW'(g))     regs[g] <= exec_data;
            end
        end
        assign cfg_flat[g*DW +: DW] = regs[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake     <= 1'b0;
            rssi_rst <= 1'b0;
            trim_req <= 1'b0;
        end else begin
            if (do_clr_wake)   wake <= 1'b0;
            else if (wake_set) wake <= 1'b1;
            rssi_rst <= is_dir && (exec_code == CMD_RSSI_RST);
            trim_req <= is_dir && (exec_code == CMD_TRIM);
        end
    end

    assign rd_data = (rd_addr < NREGS_A) ? regs[rd_addr[IW-1:0]] : '0;

    assert_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[CNT_IDX] == '1 && !exec_v) |=> (regs[CNT_IDX] == '1));

    assert_wake_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr_wake |=> !wake);

    assert_rssi_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rssi_rst |=> !rssi_rst);

    assert_trim_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trim_req |=> !trim_req);
endmodule

// File: rtl/cmdif_top.sv
module cmdif_top
    import cmdif_pkg::*;
#(
    parameter int NREGS       = 14,
    parameter int DW          = 8,
    parameter int AW          = 6,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_IDX     = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs,
    input  logic                sclk,
    input  logic                sdi,
    output logic                sdo,
    input  logic                wake_set,
    input  logic                false_wake,
    output logic                wake,
    output logic                rssi_rst,
    output logic                trim_req,
    output logic [NREGS*DW-1:0] cfg_flat
);
    localparam int NIN = 3;

    logic [NIN-1:0] raw_in, lvl, rise, fall;
    logic           exec_v;
    logic [1:0]     exec_mode;
    logic [AW-1:0]  exec_code, rd_addr;
    logic [DW-1:0]  exec_data, rd_data;

    assign raw_in = {sdi, sclk, cs};

    for (genvar i = 0; i < NIN; i++) begin : g_sync
        cmdif_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_in[i]),
            .lvl  (lvl[i]),
            .rise (rise[i]),
            .fall (fall[i])
        );
    end

    cmdif_frame_fsm #(.DW(DW), .AW(AW)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_rise  (rise[0]),
        .cs_fall  (fall[0]),
        .sclk_fall(fall[1]),
        .sdi_bit  (lvl[2]),
        .rd_data  (rd_data),
        .exec_v   (exec_v),
        .exec_mode(exec_mode),
        .exec_code(exec_code),
        .exec_data(exec_data),
        .rd_addr  (rd_addr),
        .sdo      (sdo)
    );

    cmdif_regbank #(.NREGS(NREGS), .DW(DW), .AW(AW), .CNT_IDX(CNT_IDX)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_v    (exec_v),
        .exec_mode (exec_mode),
        .exec_code (exec_code),
        .exec_data (exec_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wake_set  (wake_set),
        .false_wake(false_wake),
        .wake      (wake),
        .rssi_rst  (rssi_rst),
        .trim_req  (trim_req),
        .cfg_flat  (cfg_flat)
    );
endmodule

// File: tb/cmdif_top_tb_top.sv
module cmdif_top_tb_top;
    localparam int NREGS = 14;
    localparam int HALF  = 8;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic wake_set = 1'b0, false_wake = 1'b0;
    logic sdo, wake, rssi_rst, trim_req;
    logic [NREGS*8-1:0] cfg_flat;

    int checks = 0, errors = 0;
    int rssi_n = 0, trim_n = 0, width_bad = 0;
    logic rssi_prev = 1'b0, trim_prev = 1'b0;
    logic [7:0] model [NREGS];
    logic [7:0] rx;

    always #2 clk = ~clk;

    cmdif_top dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .wake_set(wake_set), .false_wake(false_wake), .wake(wake),
        .rssi_rst(rssi_rst), .trim_req(trim_req), .cfg_flat(cfg_flat)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rssi_rst) rssi_n++;
            if (trim_req) trim_n++;
            if ((rssi_rst && rssi_prev) || (trim_req && trim_prev)) width_bad++;
            rssi_prev = rssi_rst;
            trim_prev = trim_req;
        end
    end

    function automatic logic [7:0] dflt(input int i);
        return (i == 13) ? 8'h00 : 8'(i * 17);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREGS; i++) chk(req, int'(cfg_flat[i*8 +: 8]), int'(model[i]));
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] word, input int nbits, output logic [7:0] got);
        got = 8'h00;
        cs = 1'b1;
        hold(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            sdi  = word[15-i];
            hold(HALF);
            if (i >= 8) got = {got[6:0], sdo};
            sclk = 1'b0;
            hold(HALF);
        end
        cs  = 1'b0;
        sdi = 1'b0;
        hold(2 * HALF);
    endtask

    task automatic pulse_in(input bit which_false);
        if (which_false) false_wake = 1'b1; else wake_set = 1'b1;
        hold(1);
        false_wake = 1'b0;
        wake_set   = 1'b0;
        hold(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int r0, t0;
        for (int i = 0; i < NREGS; i++) model[i] = dflt(i);
        hold(5);
        rst_n = 1'b1;
        hold(3);

        // R1 reset state
        check_bank("R1");
        chk("R1 wake", int'(wake), 0);
        chk("R1 sdo", int'(sdo), 0);

        // R3 write sweep, R2 bit order
        for (int a = 0; a < NREGS; a++) begin
            logic [7:0] v;
            v = 8'((a * 37 + 91) & 255);
            send({2'b00, 6'(a), v}, 16, rx);
            model[a] = v;
            check_bank("R3");
        end

        // R5 read sweep
        for (int a = 0; a < NREGS; a++) begin
            send({2'b01, 6'(a), 8'h00}, 16, rx);
            chk("R5 read", int'(rx), int'(model[a]));
            chk("R5 sdo idle", int'(sdo), 0);
            check_bank("R5 no change");
        end

        // R4 out-of-range writes and reserved mode
        send({2'b00, 6'd14, 8'hAA}, 16, rx);
        send({2'b00, 6'd20, 8'hAA}, 16, rx);
        send({2'b00, 6'd63, 8'hAA}, 16, rx);
        send({2'b10, 6'd2, 8'hAA}, 16, rx);
        check_bank("R4");

        // R6 truncated frames
        send({2'b00, 6'd3, 8'h55}, 15, rx);
        send({2'b00, 6'd3, 8'h55}, 9, rx);
        check_bank("R6 short write");
        send({2'b00, 6'd13, 8'h40}, 16, rx);
        model[13] = 8'h40;
        send({2'b11, 6'd3, 8'h00}, 7, rx);
        check_bank("R6 short direct");

        // R7 clear false counter with 8-bit direct frame
        send({2'b11, 6'd3, 8'h00}, 8, rx);
        model[13] = 8'h00;
        check_bank("R7 clear_false");

        // R10 counting and saturation
        for (int k = 0; k < 3; k++) pulse_in(1'b1);
        model[13] = 8'd3;
        check_bank("R10 count");
        send({2'b00, 6'd13, 8'd253}, 16, rx);
        for (int k = 0; k < 5; k++) pulse_in(1'b1);
        model[13] = 8'd255;
        check_bank("R10 saturate");

        // R7 direct with trailing data byte ignored
        send({2'b11, 6'd3, 8'hFF}, 16, rx);
        model[13] = 8'h00;
        check_bank("R7 trailing data");

        // R8 pulses
        r0 = rssi_n; t0 = trim_n;
        send({2'b11, 6'd1, 8'h00}, 8, rx);
        chk("R8 rssi count", rssi_n - r0, 1);
        chk("R8 trim untouched", trim_n - t0, 0);
        send({2'b11, 6'd2, 8'h00}, 8, rx);
        chk("R8 trim count", trim_n - t0, 1);
        chk("R8 rssi untouched", rssi_n - r0, 1);
        send({2'b11, 6'd5, 8'h00}, 8, rx);
        chk("R7 unknown code rssi", rssi_n - r0, 1);
        chk("R7 unknown code trim", trim_n - t0, 1);
        check_bank("R7 unknown code");
        chk("R8 width", width_bad, 0);

        // R9 wake flag
        pulse_in(1'b0);
        chk("R9 set", int'(wake), 1);
        send({2'b11, 6'd1, 8'h00}, 8, rx);
        chk("R9 hold", int'(wake), 1);
        send({2'b11, 6'd0, 8'h00}, 8, rx);
        chk("R9 clear", int'(wake), 0);

        // R11 load defaults
        for (int i = 0; i < NREGS; i++) model[i] = dflt(i);
        send({2'b11, 6'd4, 8'h00}, 8, rx);
        check_bank("R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule